// File: doc/BRIEF.md
# BCD Clock Calendar Core

This block keeps the time of day and the calendar in BCD. A one-pulse-per-second tick drives a chain of counters: seconds, minutes, hours, date, month, year, century and day of week. Each counter carries into the next. The hours counter runs in either a 24-hour or a 12-hour format, and the 12-hour format has a PM flag. The day counter knows the length of every month, including 29-day Februaries in leap years.

The host reaches the block through a small register port, normally driven by an external serial-bus controller.

- Time is read through a snapshot latch. A snapshot strobe copies all eight counters in one cycle, so the returned bytes stay consistent while the clock keeps running.
- Time is written by staging bytes in a holding buffer and then issuing a commit strobe, which the bus controller raises on a valid stop. An abort strobe discards everything staged.
- A synchronous reset stands for a total loss of power. It restores every register to its default, halts counting and raises a failure flag. The first commit that carries at least one staged byte clears the flag and starts the clock.

Two state machines control the block:

- Clock machine: its states are `CLK_HALT` and `CLK_RUN`. Reset enters `CLK_HALT`. A commit of staged data takes `CLK_HALT` to `CLK_RUN`, and `CLK_RUN` holds until reset.
- Staging machine: its states are `STG_EMPTY` and `STG_HELD`. A byte write takes `STG_EMPTY` to `STG_HELD`. Inside `STG_HELD` further writes keep the state. In `STG_HELD`, either an abort or a commit returns the machine to `STG_EMPTY`. A commit only loads the counters when the staging machine is in `STG_HELD`.

Register indices:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | seconds | |
| 1 | minutes | |
| 2 | hours | see below |
| 3 | date | |
| 4 | month | |
| 5 | year | |
| 6 | day of week | |
| 7 | century | |

Hours byte layout: bit 7 is the 24-hour mode bit.
- With bit 7 at 1, bits 5:0 hold BCD 00–23.
- With bit 7 at 0, bits 4:0 hold BCD 01–12 and bit 5 is the PM flag.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the registers read seconds 00, minutes 00, hours 0x80 (24-hour, 00), date 01, month 01, year 00, weekday 0 and century 0x20. The failure flag is 1 and running is 0, and ticks leave every register unchanged until the first loading commit.
- R2: Seconds and minutes count BCD 00–59. On a tick at 59 they wrap to 00 and carry into the next counter.
- R3: In 24-hour mode (hours bit 7 = 1), hours count 00–23. On a tick at 23:59:59 the hours wrap to 00 and carry into the date.
- R4: In 12-hour mode (hours bit 7 = 0), hours count 01–12.
  - 11 goes to 12 and toggles the PM flag (bit 5).
  - 12 goes to 01 and keeps the PM flag.
  - The day carry happens only on 11 PM to 12 AM.
- R5: On the day carry, months 04, 06, 09 and 11 wrap to date 01 after 30; all other months except February wrap after 31. The wrap advances the month.
- R6: February wraps after 29 when the BCD year is divisible by 4, and after 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and sets the century to 0x20; a century of 0x20 stays 0x20.
- R8: The weekday advances by one on every day carry and wraps from 6 to 0.
- R9: `rd_data` returns the register at `rd_addr` as captured by the most recent `snap` strobe. Later ticks do not change it until the next strobe.
- R10: Staged bytes do not touch the counters before a commit. A commit replaces only the bytes staged since the buffer was last emptied; the other registers keep their values.
- R11: An abort empties the buffer. A commit with nothing staged changes no register and does not start the clock.
- R12: A commit of staged data clears the failure flag and sets running. A tick in the same cycle as the commit is ignored, and the next tick advances from the committed value.
- R13: A staged century byte other than 0x19 or 0x20 is dropped at commit, and the century keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models total power loss |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Stage `wr_data` into the buffer at `wr_addr` |
| wr_addr | input | 3 | Register index of the staged byte |
| wr_data | input | 8 | Staged byte |
| wr_abort | input | 1 | Discard all staged bytes |
| wr_commit | input | 1 | Transfer staged bytes to the counters (valid stop) |
| snap | input | 1 | Capture all counters into the read latch |
| rd_addr | input | 3 | Register index to read from the latch |
| rd_data | output | 8 | Latched register byte |
| running | output | 1 | Clock machine is in `CLK_RUN` |
| fail_flag | output | 1 | Clock machine is in `CLK_HALT` after power loss |

## Verification
The hardest situations to reach are the far ends of the carry chain: a single tick that must ripple from seconds through the year into the century, and a February 29 that exists only in a leap year. Reaching them by ticking would take millions of cycles. Instead, each scenario stages a full set of bytes just short of the boundary, commits it and issues a single tick. The commit-with-simultaneous-tick case is produced by raising both strobes on the same edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_W     = 8;
    localparam int REG_COUNT = 8;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int TOD_W     = REG_W * REG_COUNT;

    typedef logic [REG_W-1:0] byte_t;

    // Packed so that register index i sits at bits [i*REG_W +: REG_W].
    typedef struct packed {
        byte_t cent;
        byte_t wday;
        byte_t year;
        byte_t mon;
        byte_t date;
        byte_t hour;
        byte_t min;
        byte_t sec;
    } tod_t;

    localparam int IX_CENT = 7;

    localparam tod_t TOD_RESET = '{
        cent: 8'h20, wday: 8'h00, year: 8'h00, mon: 8'h01,
        date: 8'h01, hour: 8'h80, min: 8'h00, sec: 8'h00
    };

    function automatic byte_t bcd_inc(input byte_t b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic byte_t month_last_day(input byte_t mon, input byte_t year);
        logic [1:0] mod4;
        mod4 = {year[4], 1'b0} + year[1:0];
        if (mon == 8'h02) return (mod4 == 2'd0) ? 8'h29 : 8'h28;
        if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
        return 8'h31;
    endfunction
endpackage

// File: rtl/rtc_stage_buf.sv
module rtc_stage_buf
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 wr_abort,
    input  logic                 wr_commit,
    output logic                 load_fire,
    output logic [REG_COUNT-1:0] load_mask,
    output logic [TOD_W-1:0]     load_val
);
    typedef enum logic [0:0] {STG_EMPTY, STG_HELD} stg_state_e;

    stg_state_e           state_q, state_d;
    byte_t                buf_q [REG_COUNT];
    logic [REG_COUNT-1:0] mask_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_EMPTY: if (!wr_abort && !wr_commit && wr_en) state_d = STG_HELD;
            STG_HELD:  if (wr_abort || wr_commit)            state_d = STG_EMPTY;
            default:   state_d = STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= STG_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_abort || (wr_commit && state_q == STG_HELD)) begin
            mask_q <= '0;
        end else if (wr_en && !wr_commit) begin
            mask_q[wr_addr] <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < REG_COUNT; i++) begin : g_buf
            always_ff @(posedge clk) begin
                if (rst) buf_q[i] <= '0;
                else if (wr_en && !wr_abort && !wr_commit && wr_addr == IDX_W'(i))
                    buf_q[i] <= wr_data;
            end
            assign load_val[i*REG_W +: REG_W] = buf_q[i];
        end
    endgenerate

    always_comb begin
        load_fire = 1'b0;
        load_mask = mask_q;
        unique case (state_q)
            STG_EMPTY: load_fire = 1'b0;
            STG_HELD:  load_fire = wr_commit && !wr_abort;
            default:   load_fire = 1'b0;
        endcase
    end

    // R11
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_abort |=> (mask_q == '0 && !load_fire));
    // R10
    held_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == STG_HELD) |-> (mask_q != '0));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 tick,
    input  logic                 load,
    input  logic [REG_COUNT-1:0] load_mask,
    input  logic [TOD_W-1:0]     load_val,
    output logic [TOD_W-1:0]     tod_q
);
    localparam logic [TOD_W-1:0] RESET_V = TOD_RESET;

    byte_t                regs_q [REG_COUNT];
    tod_t                 cur, nxt;
    logic [TOD_W-1:0]     nxt_v;
    logic [REG_COUNT-1:0] step_en;
    logic [REG_COUNT-1:0] load_ok;
    logic                 hour_c, day_c, mon_c, year_c, year_wrap;

    assign cur   = tod_t'(tod_q);
    assign nxt_v = nxt;

    always_comb begin
        byte_t h;
        byte_t last;
        logic  sec_wrap, min_wrap;
        nxt      = cur;
        step_en  = '0;
        day_c    = 1'b0;
        sec_wrap = (cur.sec == 8'h59);
        min_wrap = (cur.min == 8'h59);
        hour_c   = sec_wrap && min_wrap;
        nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
        nxt.min  = min_wrap ? 8'h00 : bcd_inc(cur.min);
        step_en[0] = 1'b1;
        step_en[1] = sec_wrap;
        step_en[2] = hour_c;
        if (cur.hour[7]) begin
            h = {2'b00, cur.hour[5:0]};
            if (h >= 8'h23) begin
                nxt.hour = 8'h80;
                day_c    = hour_c;
            end else begin
                h        = bcd_inc(h);
                nxt.hour = {2'b10, h[5:0]};
            end
        end else begin
            h = {3'b000, cur.hour[4:0]};
            if (h == 8'h11) begin
                nxt.hour = {2'b00, ~cur.hour[5], 5'h12};
                day_c    = hour_c && cur.hour[5];
            end else if (h >= 8'h12) begin
                nxt.hour = {2'b00, cur.hour[5], 5'h01};
            end else begin
                h        = bcd_inc(h);
                nxt.hour = {2'b00, cur.hour[5], h[4:0]};
            end
        end
        last      = month_last_day(cur.mon, cur.year);
        mon_c     = day_c && (cur.date >= last);
        year_c    = mon_c && (cur.mon >= 8'h12);
        year_wrap = (cur.year >= 8'h99);
        nxt.date  = (cur.date >= last) ? 8'h01 : bcd_inc(cur.date);
        nxt.mon   = (cur.mon >= 8'h12) ? 8'h01 : bcd_inc(cur.mon);
        nxt.year  = year_wrap ? 8'h00 : bcd_inc(cur.year);
        nxt.cent  = 8'h20;
        nxt.wday  = (cur.wday >= 8'h06) ? 8'h00 : cur.wday + 8'h01;
        step_en[3] = day_c;
        step_en[4] = mon_c;
        step_en[5] = year_c;
        step_en[6] = day_c;
        step_en[7] = year_c && year_wrap;
    end

    always_comb begin
        load_ok = '1;
        load_ok[IX_CENT] = (load_val[IX_CENT*REG_W +: REG_W] == 8'h19) ||
                           (load_val[IX_CENT*REG_W +: REG_W] == 8'h20);
    end

    generate
        for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= RESET_V[i*REG_W +: REG_W];
                end else if (load) begin
                    if (load_mask[i] && load_ok[i]) regs_q[i] <= load_val[i*REG_W +: REG_W];
                end else if (run && tick && step_en[i]) begin
                    regs_q[i] <= nxt_v[i*REG_W +: REG_W];
                end
            end
            assign tod_q[i*REG_W +: REG_W] = regs_q[i];
        end
    endgenerate

    // R1
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(tod_q));
    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && cur.sec == 8'h59) |=> (cur.sec == 8'h00));
    // R7
    cent_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && year_c && year_wrap) |=> (cur.cent == 8'h20 && cur.year == 8'h00));
    // R8
    wday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && day_c && cur.wday == 8'h06) |=> (cur.wday == 8'h00));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             snap,
    input  logic [TOD_W-1:0] tod,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data
);
    localparam logic [TOD_W-1:0] RESET_V = TOD_RESET;

    logic [TOD_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst)       latch_q <= RESET_V;
        else if (snap) latch_q <= tod;
    end

    assign rd_data = latch_q[rd_addr*REG_W +: REG_W];

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(latch_q));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_abort,
    input  logic             wr_commit,
    input  logic             snap,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             running,
    output logic             fail_flag
);
    typedef enum logic [0:0] {CLK_HALT, CLK_RUN} clk_state_e;

    clk_state_e           state_q, state_d;
    logic                 load_fire;
    logic [REG_COUNT-1:0] load_mask;
    logic [TOD_W-1:0]     load_val;
    logic [TOD_W-1:0]     tod;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLK_HALT: if (load_fire) state_d = CLK_RUN;
            CLK_RUN:  state_d = CLK_RUN;
            default:  state_d = CLK_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CLK_HALT;
        else     state_q <= state_d;
    end

    always_comb begin
        running   = 1'b0;
        fail_flag = 1'b0;
        unique case (state_q)
            CLK_HALT: fail_flag = 1'b1;
            CLK_RUN:  running   = 1'b1;
            default:  fail_flag = 1'b1;
        endcase
    end

    rtc_stage_buf u_stage (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_abort(wr_abort), .wr_commit(wr_commit),
        .load_fire(load_fire), .load_mask(load_mask), .load_val(load_val)
    );

    rtc_time_chain u_chain (
        .clk(clk), .rst(rst), .run(running), .tick(tick), .load(load_fire),
        .load_mask(load_mask), .load_val(load_val), .tod_q(tod)
    );

    rtc_snapshot u_snap (
        .clk(clk), .rst(rst), .snap(snap), .tod(tod),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R12
    start_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        load_fire |=> (running && !fail_flag));
    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (running != fail_flag));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, wr_en = 1'b0, wr_abort = 1'b0, wr_commit = 1'b0, snap = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       running, fail_flag;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_abort(wr_abort), .wr_commit(wr_commit), .snap(snap),
        .rd_addr(rd_addr), .rd_data(rd_data), .running(running), .fail_flag(fail_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic stage(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic commit;
        wr_commit = 1'b1; @(negedge clk); wr_commit = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        snap = 1'b1; @(negedge clk); snap = 1'b0;
        rd_addr = 3'(a); #1 v = rd_data;
        @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input int a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
        stage(0, s); stage(1, m); stage(2, h); stage(3, d);
        stage(4, mo); stage(5, y); stage(6, w);
        commit();
    endtask

    task automatic t_reset;
        chk("R1 fail_flag", fail_flag, 1); chk("R1 running", running, 0);
        expect_reg("R1 sec", 0, 8'h00); expect_reg("R1 min", 1, 8'h00);
        expect_reg("R1 hour", 2, 8'h80); expect_reg("R1 date", 3, 8'h01);
        expect_reg("R1 mon", 4, 8'h01); expect_reg("R1 year", 5, 8'h00);
        expect_reg("R1 wday", 6, 8'h00); expect_reg("R1 cent", 7, 8'h20);
        do_ticks(3);
        expect_reg("R1 halted sec", 0, 8'h00);
        chk("R1 still halted", running, 0);
    endtask

    task automatic t_stage_commit;
        stage(0, 8'h30);
        expect_reg("R10 staged not visible", 0, 8'h00);
        chk("R10 not started", running, 0);
        commit();
        chk("R12 running", running, 1); chk("R12 flag cleared", fail_flag, 0);
        expect_reg("R10 sec loaded", 0, 8'h30);
        expect_reg("R10 min kept", 1, 8'h00);
        expect_reg("R10 hour kept", 2, 8'h80);
    endtask

    task automatic t_commit_tick;
        stage(0, 8'h10);
        wr_commit = 1'b1; tick = 1'b1; @(negedge clk); wr_commit = 1'b0; tick = 1'b0;
        expect_reg("R12 tick with commit ignored", 0, 8'h10);
        do_ticks(1);
        expect_reg("R12 next tick advances", 0, 8'h11);
    endtask

    task automatic t_abort;
        stage(0, 8'h45);
        wr_abort = 1'b1; @(negedge clk); wr_abort = 1'b0;
        commit();
        expect_reg("R11 abort discards", 0, 8'h11);
        chk("R11 still running", running, 1);
    endtask

    task automatic t_sec_min;
        set_time(8'h59, 8'h59, 8'h85, 8'h10, 8'h03, 8'h22, 8'h01);
        do_ticks(1);
        expect_reg("R2 sec wrap", 0, 8'h00); expect_reg("R2 min wrap", 1, 8'h00);
        expect_reg("R3 hour carry", 2, 8'h86);
        set_time(8'h09, 8'h19, 8'h85, 8'h10, 8'h03, 8'h22, 8'h01);
        do_ticks(1);
        expect_reg("R2 bcd digit carry", 0, 8'h10);
        expect_reg("R2 min no carry", 1, 8'h19);
    endtask

    task automatic t_24h;
        set_time(8'h59, 8'h59, 8'hA3, 8'h14, 8'h03, 8'h22, 8'h02);
        do_ticks(1);
        expect_reg("R3 23 to 00", 2, 8'h80);
        expect_reg("R3 date carry", 3, 8'h15);
        expect_reg("R8 wday step", 6, 8'h03);
    endtask

    task automatic t_12h;
        set_time(8'h59, 8'h59, 8'h11, 8'h15, 8'h03, 8'h22, 8'h02);
        do_ticks(1);
        expect_reg("R4 11AM to 12PM", 2, 8'h32);
        expect_reg("R4 no day carry", 3, 8'h15);
        set_time(8'h59, 8'h59, 8'h32, 8'h15, 8'h03, 8'h22, 8'h02);
        do_ticks(1);
        expect_reg("R4 12PM to 1PM", 2, 8'h21);
        set_time(8'h59, 8'h59, 8'h31, 8'h15, 8'h03, 8'h22, 8'h02);
        do_ticks(1);
        expect_reg("R4 11PM to 12AM", 2, 8'h12);
        expect_reg("R4 day carry", 3, 8'h16);
    endtask

    task automatic t_months;
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h22, 8'h00);
        do_ticks(1);
        expect_reg("R5 30-day wrap date", 3, 8'h01);
        expect_reg("R5 30-day wrap month", 4, 8'h05);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h05, 8'h22, 8'h00);
        do_ticks(1);
        expect_reg("R5 31-day month continues", 3, 8'h31);
    endtask

    task automatic t_feb;
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h00);
        do_ticks(1);
        expect_reg("R6 non-leap date", 3, 8'h01); expect_reg("R6 non-leap month", 4, 8'h03);
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h00);
        do_ticks(1);
        expect_reg("R6 leap 29th", 3, 8'h29); expect_reg("R6 leap month", 4, 8'h02);
        set_time(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h00);
        do_ticks(1);
        expect_reg("R6 leap wrap", 3, 8'h01); expect_reg("R6 leap wrap month", 4, 8'h03);
    endtask

    task automatic t_year;
        stage(7, 8'h19);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
        expect_reg("R13 century 19 accepted", 7, 8'h19);
        do_ticks(1);
        expect_reg("R7 month wrap", 4, 8'h01); expect_reg("R7 year wrap", 5, 8'h00);
        expect_reg("R7 century 20", 7, 8'h20); expect_reg("R8 wday 6 to 0", 6, 8'h00);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h41, 8'h03);
        do_ticks(1);
        expect_reg("R7 year step", 5, 8'h42); expect_reg("R7 century kept", 7, 8'h20);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h03);
        do_ticks(1);
        expect_reg("R7 century 20 stays", 7, 8'h20);
    endtask

    task automatic t_century_write;
        stage(7, 8'h21); commit();
        expect_reg("R13 bad century dropped", 7, 8'h20);
    endtask

    task automatic t_snapshot;
        logic [7:0] v;
        set_time(8'h05, 8'h00, 8'h80, 8'h01, 8'h01, 8'h30, 8'h00);
        rd(0, v);
        chk("R9 snapshot value", v, 8'h05);
        do_ticks(4);
        rd_addr = 3'd0; #1 chk("R9 latch held", rd_data, 8'h05);
        @(negedge clk);
        expect_reg("R9 new snapshot", 0, 8'h09);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stage_commit();
        t_commit_tick();
        t_abort();
        t_sec_min();
        t_24h();
        t_12h();
        t_months();
        t_feb();
        t_year();
        t_century_write();
        t_snapshot();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule